// File: doc/BRIEF.md
# Store-Ordering Tag and Violation Checker

This per-core unit supports hardware detection of sequential-consistency violations on a machine where a load may retire ahead of its own core's older stores. It counts the stores the core has drained from its write buffer. It gives every completed memory reference an ordering tag. It also inspects each incoming invalidation to see whether that invalidation exposes a load that was reordered over a store.

A reference's tag is the completed-store count a remote core must reach before that reference is safe to observe. A load inherits the tag of the nearest earlier reference that already holds one. A store may raise that value to the tag delivered in its coherence reply, but only when the reply marks the accessed word as unsafe. Tags, counts and serial numbers are 32-bit values that wrap, and every ordering comparison is made wrap-aware. A small window, indexed by serial number, holds the tags of recently completed references. Values evicted from that window fold into a floor value, which serves as the tag when no earlier reference is still held.

Top module: `store_order_tracker`

## Requirements
- R1: `drained_cnt_o` is 0 after reset, grows by exactly one in the cycle after each cycle with `drain_i` high, holds otherwise, and wraps modulo 2^32.
- R2: A completion event (`cmp_vld_i`) produces `tag_vld_o` high for one cycle in the next cycle, with `tag_sn_o` equal to the event's serial number. Without a completion event, `tag_vld_o` stays low, so a squashed load never receives a tag.
- R3: A completing load (`cmp_is_st_i`=0) is tagged with the tag of the held reference whose serial number is the nearest one earlier than its own. References with later serial numbers are ignored. This holds when serial numbers wrap from 0xFFFFFFFF to 0.
- R4: When no earlier reference is held, the tag is the floor value. The floor is 0 after reset and becomes the wrap-aware maximum of the tags that later completions have overwritten in the window.
- R5: A completing store whose unsafe bit `cmp_unsafe_i[cmp_word_i]` is 1 is tagged with the wrap-aware larger of the preceding tag (as in R3/R4) and `cmp_rtag_i`.
- R6: A completing store whose selected unsafe bit is 0 is tagged with the preceding tag. `cmp_rtag_i` and the unsafe bits of other words have no effect; a line filled by a read miss (tag 0, all bits clear) is therefore harmless.
- R7: An invalidation (`inv_vld_i`) raises `viol_vld_o` in the next cycle for one cycle if and only if `inv_tag_i` is wrap-aware strictly greater than `inv_cnt_i`. Equal or smaller values give no report.
- R8: During a report, `viol_st_pc_o` and `viol_acc_pc_o` equal the `inv_st_pc_i` and `inv_acc_pc_i` of the invalidation that caused it.
- R9: The wrap-aware comparison of two 32-bit values: if their bit 31 values differ, the numerically smaller value counts as the larger one; otherwise the ordinary numeric order applies.
- R10: Completion events and invalidations are accepted in every cycle, back to back, with a result for each one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| drain_i | input | 1 | A store left the write buffer this cycle |
| cmp_vld_i | input | 1 | A memory reference completes this cycle |
| cmp_is_st_i | input | 1 | 1: the completing reference is a store, 0: a load |
| cmp_sn_i | input | SW | Serial number of the completing reference |
| cmp_word_i | input | $clog2(WORDS) | Word index of a store within its line |
| cmp_unsafe_i | input | WORDS | Unsafe bits received for the store's line |
| cmp_rtag_i | input | TW | Tag received in the store's coherence reply |
| inv_vld_i | input | 1 | An invalidation arrives this cycle |
| inv_cnt_i | input | TW | Sender's completed-store count |
| inv_tag_i | input | TW | Tag of the local last access to the word |
| inv_st_pc_i | input | AW | Instruction address of the invalidating store |
| inv_acc_pc_i | input | AW | Instruction address of the local last access |
| drained_cnt_o | output | TW | Completed-store count |
| tag_vld_o | output | 1 | Tag result strobe |
| tag_sn_o | output | SW | Serial number the tag belongs to |
| tag_o | output | TW | Assigned ordering tag |
| viol_vld_o | output | 1 | Violation report strobe |
| viol_st_pc_o | output | AW | Reported invalidating store address |
| viol_acc_pc_o | output | AW | Reported local access address |

## Verification
The bench builds the block with its default parameters: 32-bit tags and serial numbers, an 8-entry window and 4-word lines. With 32-bit values, directed vectors can place tags and serial numbers on both sides of bit 31 and around 0xFFFFFFFF. The 8-entry window is small enough that a few completions evict entries and force the floor path. The random phase completes the loads of each group of four ahead of that group's stores. This exercises the search past pending stores, while the out-of-order span stays inside the window.

// File: rtl/store_order_tracker.sv
module store_order_tracker #(
  parameter int TW    = 32,
  parameter int SW    = 32,
  parameter int AW    = 32,
  parameter int DEPTH = 8,
  parameter int WORDS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     drain_i,
  input  logic                     cmp_vld_i,
  input  logic                     cmp_is_st_i,
  input  logic [SW-1:0]            cmp_sn_i,
  input  logic [$clog2(WORDS)-1:0] cmp_word_i,
  input  logic [WORDS-1:0]         cmp_unsafe_i,
  input  logic [TW-1:0]            cmp_rtag_i,
  input  logic                     inv_vld_i,
  input  logic [TW-1:0]            inv_cnt_i,
  input  logic [TW-1:0]            inv_tag_i,
  input  logic [AW-1:0]            inv_st_pc_i,
  input  logic [AW-1:0]            inv_acc_pc_i,
  output logic [TW-1:0]            drained_cnt_o,
  output logic                     tag_vld_o,
  output logic [SW-1:0]            tag_sn_o,
  output logic [TW-1:0]            tag_o,
  output logic                     viol_vld_o,
  output logic [AW-1:0]            viol_st_pc_o,
  output logic [AW-1:0]            viol_acc_pc_o
);
  localparam int IW = $clog2(DEPTH);

  function automatic logic tag_gt(input logic [TW-1:0] a, input logic [TW-1:0] b);
    return (a[TW-1] ^ b[TW-1]) ? (a < b) : (a > b);
  endfunction

  function automatic logic sn_gt(input logic [SW-1:0] a, input logic [SW-1:0] b);
    return (a[SW-1] ^ b[SW-1]) ? (a < b) : (a > b);
  endfunction

  logic [TW-1:0]    cnt_q;
  logic [TW-1:0]    floor_q;
  logic [DEPTH-1:0] e_vld;
  logic [SW-1:0]    e_sn  [DEPTH];
  logic [TW-1:0]    e_tag [DEPTH];

  logic             hit;
  logic [SW-1:0]    best_sn;
  logic [TW-1:0]    best_tag;
  logic [TW-1:0]    prev_tag;
  logic [TW-1:0]    new_tag;
  logic [IW-1:0]    slot;
  logic             ubit;
  logic             evict;

  always_comb begin
    hit      = 1'b0;
    best_sn  = '0;
    best_tag = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (e_vld[i] && sn_gt(cmp_sn_i, e_sn[i]) && (!hit || sn_gt(e_sn[i], best_sn))) begin
        hit      = 1'b1;
        best_sn  = e_sn[i];
        best_tag = e_tag[i];
      end
    end
  end

  assign prev_tag = hit ? best_tag : floor_q;
  assign slot     = cmp_sn_i[IW-1:0];
  assign ubit     = cmp_unsafe_i[cmp_word_i];
  assign new_tag  = (cmp_is_st_i && ubit && tag_gt(cmp_rtag_i, prev_tag)) ? cmp_rtag_i : prev_tag;
  assign evict    = e_vld[slot] && (e_sn[slot] != cmp_sn_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      floor_q <= '0;
      e_vld   <= '0;
    end else begin
      if (drain_i) cnt_q <= cnt_q + TW'(1);
      if (cmp_vld_i) begin
        e_vld[slot] <= 1'b1;
        if (evict && tag_gt(e_tag[slot], floor_q)) floor_q <= e_tag[slot];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (cmp_vld_i) begin
      e_sn[slot]  <= cmp_sn_i;
      e_tag[slot] <= new_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_vld_o     <= 1'b0;
      tag_sn_o      <= '0;
      tag_o         <= '0;
      viol_vld_o    <= 1'b0;
      viol_st_pc_o  <= '0;
      viol_acc_pc_o <= '0;
    end else begin
      tag_vld_o  <= cmp_vld_i;
      viol_vld_o <= inv_vld_i && tag_gt(inv_tag_i, inv_cnt_i);
      if (cmp_vld_i) begin
        tag_sn_o <= cmp_sn_i;
        tag_o    <= new_tag;
      end
      if (inv_vld_i) begin
        viol_st_pc_o  <= inv_st_pc_i;
        viol_acc_pc_o <= inv_acc_pc_i;
      end
    end
  end

  assign drained_cnt_o = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    drain_i |=> drained_cnt_o == $past(drained_cnt_o) + TW'(1)); // R1
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !drain_i |=> $stable(drained_cnt_o)); // R1
  AST_TAG_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_vld_i |=> tag_vld_o && tag_sn_o == $past(cmp_sn_i)); // R2
  AST_NO_STRAY_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_vld_i |=> !tag_vld_o); // R2
  AST_RX_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_vld_i && cmp_is_st_i && cmp_unsafe_i[cmp_word_i] |=> !tag_gt($past(cmp_rtag_i), tag_o)); // R5
  AST_NO_FALSE_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
    inv_vld_i && !tag_gt(inv_tag_i, inv_cnt_i) |=> !viol_vld_o); // R7
  AST_VIOL_NEEDS_INV: assert property (@(posedge clk) disable iff (!rst_n)
    !inv_vld_i |=> !viol_vld_o); // R7
  AST_VIOL_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    inv_vld_i |=> viol_st_pc_o == $past(inv_st_pc_i) && viol_acc_pc_o == $past(inv_acc_pc_i)); // R8
endmodule

// File: tb/store_order_tracker_tb.sv
module store_order_tracker_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, drain_i, cmp_vld_i, cmp_is_st_i, inv_vld_i;
  logic [31:0] cmp_sn_i, cmp_rtag_i, inv_cnt_i, inv_tag_i, inv_st_pc_i, inv_acc_pc_i;
  logic [1:0]  cmp_word_i;
  logic [3:0]  cmp_unsafe_i;
  logic [31:0] drained_cnt_o, tag_sn_o, tag_o, viol_st_pc_o, viol_acc_pc_o;
  logic        tag_vld_o, viol_vld_o;

  store_order_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .drain_i(drain_i),
    .cmp_vld_i(cmp_vld_i), .cmp_is_st_i(cmp_is_st_i), .cmp_sn_i(cmp_sn_i),
    .cmp_word_i(cmp_word_i), .cmp_unsafe_i(cmp_unsafe_i), .cmp_rtag_i(cmp_rtag_i),
    .inv_vld_i(inv_vld_i), .inv_cnt_i(inv_cnt_i), .inv_tag_i(inv_tag_i),
    .inv_st_pc_i(inv_st_pc_i), .inv_acc_pc_i(inv_acc_pc_i),
    .drained_cnt_o(drained_cnt_o), .tag_vld_o(tag_vld_o), .tag_sn_o(tag_sn_o), .tag_o(tag_o),
    .viol_vld_o(viol_vld_o), .viol_st_pc_o(viol_st_pc_o), .viol_acc_pc_o(viol_acc_pc_o)
  );

  int nchk = 0, nbad = 0;
  bit done = 0;
  bit ex_tv, ex_vv;
  logic [31:0] ex_sn, ex_tag, ex_spc, ex_apc, ex_cnt;
  string ex_treq, ex_vreq;
  logic [31:0] rec_sn [64];
  logic [31:0] rec_tag[64];
  bit          rec_ok [64];

  function automatic bit wgt(input logic [31:0] a, input logic [31:0] b);
    if (a[31] != b[31]) return a < b;
    return a > b;
  endfunction

  function automatic logic [31:0] nearest(input logic [31:0] s);
    for (int k = 1; k <= 8; k++) begin
      logic [31:0] p;
      p = s - 32'(k);
      if (rec_ok[p[5:0]] && rec_sn[p[5:0]] == p) return rec_tag[p[5:0]];
    end
    return 32'd0;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    drain_i = 0; cmp_vld_i = 0; cmp_is_st_i = 0; cmp_sn_i = 0; cmp_word_i = 0;
    cmp_unsafe_i = 0; cmp_rtag_i = 0; inv_vld_i = 0; inv_cnt_i = 0; inv_tag_i = 0;
    inv_st_pc_i = 0; inv_acc_pc_i = 0; ex_tv = 0; ex_vv = 0; ex_vreq = "R7";
  endtask

  task automatic step();
    @(posedge clk); #2;
    chk("R2", "tag_vld", 32'(tag_vld_o), 32'(ex_tv));
    if (ex_tv) begin
      chk("R2", "tag_sn", tag_sn_o, ex_sn);
      chk(ex_treq, "tag", tag_o, ex_tag);
    end
    chk(ex_vreq, "viol_vld", 32'(viol_vld_o), 32'(ex_vv));
    if (ex_vv) begin
      chk("R8", "viol_st_pc", viol_st_pc_o, ex_spc);
      chk("R8", "viol_acc_pc", viol_acc_pc_o, ex_apc);
    end
    chk("R1", "drained_cnt", drained_cnt_o, ex_cnt);
    @(negedge clk);
    idle();
  endtask

  task automatic cmp(input bit st, input logic [31:0] sn, input logic [1:0] w,
                     input logic [3:0] u, input logic [31:0] rt, input logic [31:0] et, input string req);
    cmp_vld_i = 1; cmp_is_st_i = st; cmp_sn_i = sn; cmp_word_i = w; cmp_unsafe_i = u; cmp_rtag_i = rt;
    ex_tv = 1; ex_sn = sn; ex_tag = et; ex_treq = req;
  endtask

  task automatic inv(input logic [31:0] tg, input logic [31:0] cn, input logic [31:0] spc,
                     input logic [31:0] apc, input bit exp, input string req);
    inv_vld_i = 1; inv_tag_i = tg; inv_cnt_i = cn; inv_st_pc_i = spc; inv_acc_pc_i = apc;
    ex_vv = exp; ex_spc = spc; ex_apc = apc; ex_vreq = req;
  endtask

  task automatic drain();
    drain_i = 1; ex_cnt = ex_cnt + 1;
  endtask

  task automatic do_reset();
    idle(); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; ex_cnt = 0;
    for (int i = 0; i < 64; i++) rec_ok[i] = 0;
    step();
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; idle(); ex_cnt = 0;
    @(negedge clk);
    do_reset();
    // R4: first reference, empty window -> floor 0
    cmp(0, 32'd1, 0, 4'h0, 32'd0, 32'd0, "R4"); step();
    // R5: unsafe bit of word 2 set
    cmp(1, 32'd2, 2, 4'b0100, 32'd100, 32'd100, "R5"); drain(); step();
    // R6: word 1 bit clear, other bits set, large rtag ignored
    cmp(1, 32'd3, 1, 4'b1101, 32'd500, 32'd100, "R6"); drain(); step();
    // R3: back-to-back loads evicting SN 2 and 3 (R10)
    cmp(0, 32'd10, 0, 4'h0, 32'd0, 32'd100, "R3"); step();
    cmp(0, 32'd11, 0, 4'h0, 32'd0, 32'd100, "R3"); step();
    // R4: nothing earlier than SN 0 is held -> floor raised to 100
    cmp(0, 32'd0, 0, 4'h0, 32'd0, 32'd100, "R4"); step();
    // R9: received tag FFFFFFF0 is smaller than 100 under wrap rule
    cmp(1, 32'd12, 3, 4'b1000, 32'hFFFF_FFF0, 32'd100, "R9"); step();
    cmp(1, 32'd13, 3, 4'b1000, 32'd200, 32'd200, "R5"); step();
    // R7/R8/R9 invalidations
    inv(32'd11, 32'd10, 32'hA000, 32'hB000, 1, "R7"); step();
    inv(32'd11, 32'd11, 32'hA004, 32'hB004, 0, "R7"); step();
    inv(32'd10, 32'd11, 32'hA008, 32'hB008, 0, "R7"); step();
    inv(32'd1, 32'hFFFF_FFF0, 32'hA00C, 32'hB00C, 1, "R9"); step();
    inv(32'hFFFF_FFF0, 32'd5, 32'hA010, 32'hB010, 0, "R9"); step();
    // R1: idle cycles keep count; drains advance it
    step(); drain(); step(); drain(); step(); step();

    // R3/R9: serial-number wrap
    do_reset();
    cmp(1, 32'hFFFF_FFFF, 0, 4'b0001, 32'd77, 32'd77, "R5"); step();
    cmp(0, 32'd0, 0, 4'h0, 32'd0, 32'd77, "R3"); step();

    // random phase: groups of four, loads may complete ahead of stores
    do_reset();
    for (int c = 0; c < 300; c++) begin
      bit          st [4];
      int          ord[4];
      int          n;
      logic [31:0] base;
      base = 32'(1 + 4 * c);
      for (int j = 0; j < 4; j++) st[j] = bit'($urandom % 2);
      n = 0;
      if ($urandom % 2 == 0) begin
        for (int j = 0; j < 4; j++) begin ord[n] = j; n++; end
      end else begin
        for (int j = 0; j < 4; j++) if (!st[j]) begin ord[n] = j; n++; end
        for (int j = 0; j < 4; j++) if (st[j]) begin ord[n] = j; n++; end
      end
      for (int j = 0; j < 4; j++) begin
        logic [31:0] s, pv, rt, et, tg, cn;
        logic [1:0]  w;
        logic [3:0]  u;
        bit          isst;
        if ($urandom % 5 == 0) begin
          if ($urandom % 2 == 0) drain();
          step();
        end
        s = base + 32'(ord[j]);
        isst = st[ord[j]];
        w = 2'($urandom % 4);
        u = 4'($urandom % 16);
        rt = 32'($urandom % 600);
        pv = nearest(s);
        et = (isst && u[w] && wgt(rt, pv)) ? rt : pv;
        rec_sn[s[5:0]] = s; rec_tag[s[5:0]] = et; rec_ok[s[5:0]] = 1;
        cmp(isst, s, w, u, rt, et, isst ? (u[w] ? "R5" : "R6") : "R3");
        if ($urandom % 2 == 0) drain();
        if ($urandom % 3 == 0) begin
          tg = 32'($urandom % 600);
          case ($urandom % 4)
            0: cn = tg - 1;
            1: cn = tg;
            2: cn = tg + 1;
            default: cn = 32'($urandom % 600);
          endcase
          inv(tg, cn, $urandom, $urandom, wgt(tg, cn), "R10");
        end
        step();
      end
    end
    done = 1;
    summary();
    $finish;
  end
endmodule